// File: doc/BRIEF.md
# Sector Write Guard

This block decides whether a write operation at a 24-bit byte address may proceed in a 16 Mbit array of 512 sectors of 4 KB each, grouped into 32 blocks of 16 sectors. It holds a 512-bit guard register, one bit per sector. A bit at 0 marks its sector as protected. A single-sector lock window adds a second layer. Once the window is armed, every sector is read-only except the one sector it names. The rest of that sector's block stays read-only too.

A command port changes this state. It can erase the guard register, clear guard bits one byte at a time, lock everything, or open one sector. A separate query port takes an address and an operation class. One cycle later it answers allow or deny. The two ports are independent and can both be active in the same cycle.

Top module: `sector_guard`

## Requirements
- R1: While reset is asserted and in the first cycle after it, qRespValid is 0. After reset every guard bit reads as unprotected and the lock window is disarmed, so every write query is allowed.
- R2: A query accepted with qValid=1 gets exactly one response, with qRespValid=1, in the following cycle. A read query (qOp=0) is always allowed.
- R3: A page program query (qOp=1) or a sector erase query (qOp=2) concerns sector qAddr[20:12]. It is denied when that sector's guard bit is 0, whatever the lock window holds.
- R4: A guard program command (cmdOp=2) uses cmdAddr[5:0] to select byte i of the guard register. Bit k of that byte is the guard bit of sector 8*i+k. Each 0 in cmdData clears the matching guard bit. Each 1 leaves its bit unchanged, so no guard bit can return to 1 through this command.
- R5: A guard erase command (cmdOp=1) sets all 512 guard bits to 1.
- R6: A block erase query (qOp=3) concerns block qAddr[20:16]. It is allowed only when all 16 guard bits of that block are 1 and the lock window is disarmed.
- R7: A chip erase query (any qOp from 4 to 7) is allowed only when all 512 guard bits are 1 and the lock window is disarmed.
- R8: A lock command (cmdOp=3) arms the lock window with no sector open. After it, every program, erase and block erase query is denied.
- R9: An unlock command (cmdOp=4) arms the lock window and opens sector cmdAddr[20:12]; bits cmdAddr[11:0] are ignored. Program and sector erase queries to the open sector are then judged by its guard bit alone. Every other sector, including the other 15 sectors of the same block, stays denied.
- R10: A new unlock command replaces the previously open sector.
- R11: A lock command issued after an unlock closes the open sector.
- R12: A query and a command in the same cycle: the query is judged on the state from before the command. The command takes effect for queries from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 3 | Command code: 0 none, 1 guard erase, 2 guard program, 3 lock, 4 unlock; other codes are no-ops |
| cmdAddr | input | 24 | Command address (byte select for guard program, sector for unlock) |
| cmdData | input | 8 | Clear mask for guard program |
| qValid | input | 1 | Query strobe |
| qOp | input | 3 | Query class: 0 read, 1 program, 2 sector erase, 3 block erase, 4 to 7 chip erase |
| qAddr | input | 24 | Query address |
| qRespValid | output | 1 | Response strobe, one cycle after the query |
| qAllow | output | 1 | 1 when the queried operation is permitted |

## Verification
A command and a query can land on the same clock edge. The interesting pairs are a guard program clearing the very sector being queried, and an unlock opening it. The bench drives such pairs in one cycle. Its scoreboard computes the expected answer from its model before it applies the command, so an answer that already reflects the command is reported. A query in the next cycle then confirms that the command took effect.

// File: rtl/sgpkg.sv
package sgpkg;
  localparam int ADDR_W       = 24;
  localparam int SECT_SHIFT   = 12;
  localparam int SECT_IDX_W   = 9;
  localparam int BLK_SECT_LOG = 4;
  localparam int NUM_SECT     = 1 << SECT_IDX_W;
  localparam int BLK_SECT     = 1 << BLK_SECT_LOG;
  localparam int BLK_IDX_W    = SECT_IDX_W - BLK_SECT_LOG;
  localparam int NUM_BLK      = 1 << BLK_IDX_W;
  localparam int BYTE_IDX_W   = SECT_IDX_W - 3;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0, CMD_GUARD_ERASE = 3'd1, CMD_GUARD_PROG = 3'd2,
    CMD_LOCK = 3'd3, CMD_UNLOCK = 3'd4
  } cmdOp_e;

  typedef enum logic [2:0] {
    Q_READ = 3'd0, Q_PROG = 3'd1, Q_SECT_ERASE = 3'd2, Q_BLK_ERASE = 3'd3
  } qOp_e;

  typedef struct packed {
    logic                  eraseAll;
    logic                  progByte;
    logic                  lockAll;
    logic                  unlockOne;
    logic [BYTE_IDX_W-1:0] byteIdx;
    logic [7:0]            byteMask;
    logic [SECT_IDX_W-1:0] cmdSect;
    logic                  qValid;
    logic                  qRead;
    logic                  qSect;
    logic                  qBlk;
    logic                  qChip;
    logic [SECT_IDX_W-1:0] qSectIdx;
  } sgStrobe_t;
endpackage

// File: rtl/sg_ctrl.sv
module sg_ctrl
  import sgpkg::*;
(
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [7:0]        cmdData,
  input  logic              qValid,
  input  logic [2:0]        qOp,
  input  logic [ADDR_W-1:0] qAddr,
  output sgStrobe_t         stb
);
  logic unusedAddrBits;
  assign unusedAddrBits = ^{cmdAddr[ADDR_W-1:SECT_SHIFT+SECT_IDX_W],
                            cmdAddr[SECT_SHIFT-1:BYTE_IDX_W],
                            qAddr[ADDR_W-1:SECT_SHIFT+SECT_IDX_W],
                            qAddr[SECT_SHIFT-1:0]};

  always_comb begin
    stb          = '0;
    stb.byteIdx  = cmdAddr[BYTE_IDX_W-1:0];
    stb.byteMask = cmdData;
    stb.cmdSect  = cmdAddr[SECT_SHIFT +: SECT_IDX_W];
    stb.qSectIdx = qAddr[SECT_SHIFT +: SECT_IDX_W];
    stb.qValid   = qValid;
    if (cmdValid) begin
      case (cmdOp_e'(cmdOp))
        CMD_GUARD_ERASE: stb.eraseAll  = 1'b1;
        CMD_GUARD_PROG:  stb.progByte  = 1'b1;
        CMD_LOCK:        stb.lockAll   = 1'b1;
        CMD_UNLOCK:      stb.unlockOne = 1'b1;
        default: ;
      endcase
    end
    if (qValid) begin
      case (qOp_e'(qOp))
        Q_READ:       stb.qRead = 1'b1;
        Q_PROG:       stb.qSect = 1'b1;
        Q_SECT_ERASE: stb.qSect = 1'b1;
        Q_BLK_ERASE:  stb.qBlk  = 1'b1;
        default:      stb.qChip = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/sg_datapath.sv
module sg_datapath
  import sgpkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  sgStrobe_t stb,
  output logic      qRespValid,
  output logic      qAllow
);
  logic [NUM_SECT-1:0]   guard;
  logic                  lockMode;
  logic                  unlockValid;
  logic [SECT_IDX_W-1:0] unlockSect;
  logic [NUM_BLK-1:0]    blockOk;
  logic [BLK_IDX_W-1:0]  qBlkIdx;
  logic                  sectOpen;
  logic                  wideOk;
  logic                  allowNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      guard <= '1;
    end else if (stb.eraseAll) begin
      guard <= '1;
    end else if (stb.progByte) begin
      guard[{stb.byteIdx, 3'b000} +: 8] <= guard[{stb.byteIdx, 3'b000} +: 8] & stb.byteMask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockMode    <= 1'b0;
      unlockValid <= 1'b0;
      unlockSect  <= '0;
    end else if (stb.lockAll) begin
      lockMode    <= 1'b1;
      unlockValid <= 1'b0;
    end else if (stb.unlockOne) begin
      lockMode    <= 1'b1;
      unlockValid <= 1'b1;
      unlockSect  <= stb.cmdSect;
    end
  end

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    assign blockOk[b] = &guard[b*BLK_SECT +: BLK_SECT];
  end

  assign qBlkIdx  = stb.qSectIdx[SECT_IDX_W-1 -: BLK_IDX_W];
  assign sectOpen = guard[stb.qSectIdx] &&
                    (!lockMode || (unlockValid && (unlockSect == stb.qSectIdx)));
  assign wideOk   = !lockMode && (stb.qChip ? (&blockOk) : blockOk[qBlkIdx]);
  assign allowNext = stb.qRead || (stb.qSect ? sectOpen : wideOk);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qRespValid <= 1'b0;
      qAllow     <= 1'b0;
    end else begin
      qRespValid <= stb.qValid;
      qAllow     <= stb.qValid && allowNext;
    end
  end

  AST_ERASE_FILLS: assert property (@(posedge clk) disable iff (!rstN)
    stb.eraseAll |=> (&guard)); // R5
  AST_NO_BIT_SET: assert property (@(posedge clk) disable iff (!rstN)
    !stb.eraseAll |=> ((guard & ~$past(guard)) == '0)); // R4
  AST_READ_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    (stb.qValid && stb.qRead) |=> (qRespValid && qAllow)); // R2
  AST_WIDE_NEEDS_NO_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (qAllow && $past(stb.qBlk || stb.qChip)) |-> !$past(lockMode)); // R6
  AST_LOCK_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    stb.lockAll |=> (lockMode && !unlockValid)); // R11
endmodule

// File: rtl/sector_guard.sv
module sector_guard
  import sgpkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [7:0]        cmdData,
  input  logic              qValid,
  input  logic [2:0]        qOp,
  input  logic [ADDR_W-1:0] qAddr,
  output logic              qRespValid,
  output logic              qAllow
);
  sgStrobe_t stb;

  sg_ctrl u_ctrl (
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .qValid(qValid), .qOp(qOp), .qAddr(qAddr), .stb(stb)
  );

  sg_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .qRespValid(qRespValid), .qAllow(qAllow)
  );
endmodule

// File: tb/sector_guard_tb.sv
`timescale 1ns/1ps
module sector_guard_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdOp = '0;
  logic [23:0] cmdAddr = '0;
  logic [7:0]  cmdData = '0;
  logic        qValid = 1'b0;
  logic [2:0]  qOp = '0;
  logic [23:0] qAddr = '0;
  logic        qRespValid;
  logic        qAllow;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    bit    allow;
    string tag;
  } item_t;
  item_t expQ[$];

  bit       mGuard [512];
  bit       mLock;
  bit       mUv;
  bit [8:0] mUs;

  always #2.5 clk = ~clk;

  sector_guard u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .cmdData(cmdData), .qValid(qValid), .qOp(qOp), .qAddr(qAddr),
    .qRespValid(qRespValid), .qAllow(qAllow)
  );

  function automatic bit expAllow(int op, logic [23:0] a);
    bit [8:0] s;
    bit ok;
    s = a[20:12];
    if (op == 0) return 1'b1;
    if (op == 1 || op == 2) return mGuard[s] && (!mLock || (mUv && mUs == s));
    ok = !mLock;
    if (op == 3) begin
      for (int k = 0; k < 16; k++) if (!mGuard[{a[20:16], 4'(k)}]) ok = 1'b0;
    end else begin
      for (int k = 0; k < 512; k++) if (!mGuard[k]) ok = 1'b0;
    end
    return ok;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive one cycle: optional command and optional query together
  task automatic drive(bit cv, int cop, logic [23:0] ca, logic [7:0] cd,
                       bit qv, int qop, logic [23:0] qa, string tag);
    item_t it;
    @(negedge clk);
    cmdValid = cv; cmdOp = 3'(cop); cmdAddr = ca; cmdData = cd;
    qValid = qv; qOp = 3'(qop); qAddr = qa;
    if (qv) begin
      it.allow = expAllow(qop, qa);
      it.tag = tag;
      expQ.push_back(it);
    end
    if (cv) begin
      case (cop)
        1: for (int k = 0; k < 512; k++) mGuard[k] = 1'b1;
        2: for (int k = 0; k < 8; k++) if (!cd[k]) mGuard[{ca[5:0], 3'(k)}] = 1'b0;
        3: begin mLock = 1'b1; mUv = 1'b0; end
        4: begin mLock = 1'b1; mUv = 1'b1; mUs = ca[20:12]; end
        default: ;
      endcase
    end
  endtask

  task automatic cmd(int cop, logic [23:0] ca, logic [7:0] cd);
    drive(1'b1, cop, ca, cd, 1'b0, 0, '0, "");
  endtask

  task automatic query(int qop, logic [23:0] qa, string tag);
    drive(1'b0, 0, '0, '0, 1'b1, qop, qa, tag);
  endtask

  // monitor: pop and compare each response
  always @(negedge clk) begin
    if (rstN && qRespValid) begin
      if (expQ.size() == 0) begin
        check("R2 unexpected response", 1, 0);
      end else begin
        item_t it;
        it = expQ.pop_front();
        check(it.tag, int'(qAllow), int'(it.allow));
      end
    end
  end

  initial begin
    for (int k = 0; k < 512; k++) mGuard[k] = 1'b1;
    mLock = 1'b0; mUv = 1'b0; mUs = '0;
    repeat (3) @(negedge clk);
    check("R1 no response in reset", int'(qRespValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 no response after reset", int'(qRespValid), 0);
    query(1, 24'h000000, "R1 program after reset");
    query(4, 24'h000000, "R1 R7 chip erase after reset");
    query(3, 24'h1F0000, "R1 R6 block erase after reset");
    query(0, 24'h000000, "R2 read");
    // protect sector 0
    cmd(2, 24'h000000, 8'hFE);
    query(1, 24'h000123, "R3 program protected sector 0");
    query(2, 24'h001000, "R3 sector erase sector 1 open");
    query(3, 24'h00FFFF, "R6 block erase block 0 denied");
    query(3, 24'h010000, "R6 block erase block 1 allowed");
    query(7, 24'h000000, "R7 chip erase denied");
    query(0, 24'h000000, "R2 read protected sector");
    // ones in mask do not set bits
    cmd(2, 24'h000000, 8'hFD);
    query(1, 24'h000000, "R4 sector 0 stays protected");
    query(1, 24'h001000, "R4 sector 1 now protected");
    query(1, 24'h002000, "R4 sector 2 untouched");
    cmd(2, 24'h00003F, 8'h7F);
    query(2, 24'h1FF000, "R4 last byte bit 7 is sector 511");
    query(2, 24'h1FE000, "R4 sector 510 untouched");
    cmd(1, '0, '0);
    query(1, 24'h000000, "R5 erase reopens sector 0");
    query(4, 24'h000000, "R5 R7 chip erase after guard erase");
    // same-cycle command and query
    drive(1'b1, 2, 24'h000002, 8'h00, 1'b1, 1, 24'h010000, "R12 program with query pre-state");
    query(1, 24'h010000, "R12 R3 sector 16 now protected");
    query(1, 24'h017000, "R3 sector 23 protected");
    query(1, 24'h018000, "R3 sector 24 open");
    cmd(1, '0, '0);
    // lock mode
    cmd(3, '0, '0);
    query(1, 24'h064000, "R8 program denied when locked");
    query(2, 24'h000000, "R8 sector erase denied when locked");
    query(3, 24'h050000, "R8 block erase denied when locked");
    query(0, 24'h064000, "R2 read while locked");
    cmd(4, 24'h123ABC, '0);
    query(1, 24'h123000, "R9 open sector allowed");
    query(2, 24'h123FFF, "R9 low bits ignored");
    query(1, 24'h122000, "R9 neighbour in block denied");
    query(1, 24'h12F000, "R9 block neighbour denied");
    query(3, 24'h120000, "R9 R6 block of open sector denied");
    query(4, 24'h000000, "R7 chip erase denied in lock window");
    drive(1'b1, 4, 24'h050000, '0, 1'b1, 1, 24'h050000, "R12 unlock with query pre-state");
    query(1, 24'h123000, "R10 previous sector closed");
    query(1, 24'h050000, "R10 new sector open");
    cmd(2, 24'h00000A, 8'hFE);
    query(1, 24'h050000, "R3 guard overrides unlock");
    cmd(1, '0, '0);
    query(1, 24'h050000, "R10 open sector after guard erase");
    cmd(3, '0, '0);
    query(1, 24'h050000, "R11 lock closes sector");
    query(0, 24'h050000, "R2 read after relock");
    @(negedge clk);
    qValid = 1'b0; cmdValid = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 all responses seen", expQ.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #20000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule